// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a small field-configurable logic device. Eleven dedicated data inputs and ten feedback signals feed an AND plane of product terms. Each product term can connect the true form, the complemented form, or neither form of every array input. Ten output cells each OR together their own group of product terms. Each cell then either passes that sum straight through or captures it in a flip-flop on the shared clock, and can invert the result. Every cell also has a product term of its own that drives its output enable.

Two shared product terms act on all ten flip-flops. One sets every register at the next clock edge. The other clears every register at once, without waiting for the clock. A test preload port can write any pattern into the registers directly. The whole configuration is written one row per cycle through a parallel port while a configure-enable input is high. That configuration is the fuse rows plus one control row holding the mode bit and the polarity bit of each cell. While configure-enable is high, every output is held disabled.

Top module: `pal_array_top`

## Requirements
- R1: Array input j is din[j] for j below 11 and the feedback of cell j-11 otherwise. In a fuse row, bit 2j set connects the true literal of input j and bit 2j+1 set connects its complement. A term is the AND of its connected literals, so a row with no bit set is 1 and a row connecting both literals of any input is 0.
- R2: Rows 0 to 119 are sum terms. Cell i owns 8+2*min(i,9-i) consecutive rows, placed after the rows of all lower-numbered cells. Its sum is the OR of those rows.
- R3: With mode bit i clear, the cell is combinational and pin_o[i] equals its sum, inverted when polarity bit i is set.
- R4: With mode bit i set, the cell's register takes its sum on a rising clk edge, and pin_o[i] equals the register XOR polarity bit i.
- R5: pin_oe[i] equals the term in row 120+i, and is 0 for every cell while cfg_en is high.
- R6: The feedback of a registered cell is its register, and the feedback of a combinational cell is pin_i[i].
- R7: When the term in row 131 is true at a clock edge, every register becomes 1, unless a higher-priority action applies.
- R8: While the term in row 130 is true, every register is 0 at once, without a clock edge. This clear overrides set, preload and reset.
- R9: pre_en high at a clock edge loads pre_data into the registers. Preload overrides the set term and the logic.
- R10: A configuration write happens only at a rising edge with both cfg_en and cfg_we high, and cfg_we alone has no effect. Row 132 is the control row: bits 0 to 9 are the mode bits (1 = registered) and bits 10 to 19 are the polarity bits (1 = inverted). The registers are held at 0 while cfg_en is high.
- R11: rst_n low at a rising edge sets every fuse row to all ones, clears the control row and clears the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for the registers and the configuration writes |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configure mode: writes allowed, outputs disabled, registers held at 0 |
| cfg_we | input | 1 | Write strobe for one configuration row |
| cfg_addr | input | 8 | Row index: 0-131 are fuse rows, 132 is the control row |
| cfg_data | input | 42 | Row contents |
| din | input | 11 | Dedicated logic inputs |
| pin_i | input | 10 | Level sensed at each output pad |
| pre_en | input | 1 | Register preload strobe |
| pre_data | input | 10 | Preload pattern |
| pin_o | output | 10 | Output data of each cell |
| pin_oe | output | 10 | Output enable of each cell |

## Verification
The properties on set, preload and clear assume that the clear term is built only from dedicated inputs. A clear term fed from a register's own feedback would pulse and release within the same cycle. The stimulus keeps to this: every clear row it writes, directed or random, uses only din columns. It also changes inputs only shortly after the falling clock edge, so the clear is settled well before the edge the properties sample. Each random configuration draws sparse rows, so that sums, enables and the set term switch often instead of sitting at a constant 0.

// File: rtl/pal_cfg_pkg.sv
`timescale 1ns/1ps
// Package: sizing helpers shared by the logic array and its bench.
// Assumes product-term counts rise by a fixed step from both ends toward the middle cell.
package pal_cfg_pkg;

    // Number of sum terms owned by cell idx.
    function automatic int pt_count(int idx, int n_mc, int pt_min, int pt_step);
        int half;
        half = (idx < n_mc - 1 - idx) ? idx : n_mc - 1 - idx;
        return pt_min + pt_step * half;
    endfunction

    // First sum-term row of cell idx (equals the total when idx == n_mc).
    function automatic int pt_offset(int idx, int n_mc, int pt_min, int pt_step);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) begin
            acc += pt_count(k, n_mc, pt_min, pt_step);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pal_fuse_store.sv
`timescale 1ns/1ps
// Module: configuration storage for the AND-plane rows and the per-cell control bits.
// Assumes one row is written per cycle. Reset returns every fuse to intact (all ones).
module pal_fuse_store #(
    parameter int N_TERMS = 132,
    parameter int ROW_W   = 42,
    parameter int N_MC    = 10,
    parameter int AW      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_en,
    input  logic                     cfg_we,
    input  logic [AW-1:0]            cfg_addr,
    input  logic [ROW_W-1:0]         cfg_data,
    output logic [N_TERMS*ROW_W-1:0] plane,
    output logic [N_MC-1:0]          reg_mode,
    output logic [N_MC-1:0]          invert
);
    localparam int CTRL_ROW = N_TERMS;

    logic [ROW_W-1:0]  rows_q [N_TERMS];
    logic [2*N_MC-1:0] ctrl_q;
    logic              wr_ok;

    // A write needs both the configure mode and the strobe.
    assign wr_ok = cfg_en & cfg_we;

    // Fuse rows: cleared to intact on reset, otherwise written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N_TERMS; r++) begin
                rows_q[r] <= '1;
            end
        end else begin
            for (int r = 0; r < N_TERMS; r++) begin
                if (wr_ok && cfg_addr == AW'(r)) begin
                    rows_q[r] <= cfg_data;
                end
            end
        end
    end

    // Control row: mode bits low, polarity bits above them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ok && cfg_addr == AW'(CTRL_ROW)) begin
            ctrl_q <= cfg_data[2*N_MC-1:0];
        end
    end

    // Flatten the rows into one vector for the AND plane.
    for (genvar r = 0; r < N_TERMS; r++) begin : g_flat
        assign plane[r*ROW_W +: ROW_W] = rows_q[r];
    end

    assign reg_mode = ctrl_q[N_MC-1:0];
    assign invert   = ctrl_q[2*N_MC-1:N_MC];

endmodule

// File: rtl/pal_and_plane.sv
`timescale 1ns/1ps
// Module: programmable AND plane producing every product term in parallel.
// Assumes two fuse bits per input (true at 2j, complement at 2j+1); a set bit connects the literal.
module pal_and_plane #(
    parameter int N_TERMS = 132,
    parameter int N_AIN   = 21
) (
    input  logic [N_TERMS*2*N_AIN-1:0] fuses,
    input  logic [N_AIN-1:0]           lits,
    output logic [N_TERMS-1:0]         terms
);
    localparam int ROW_W = 2 * N_AIN;

    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        logic [ROW_W-1:0] row;
        logic             hit;

        assign row = fuses[t*ROW_W +: ROW_W];

        // AND of all connected literals; any connected literal that is false kills the term.
        always_comb begin
            hit = 1'b1;
            for (int j = 0; j < N_AIN; j++) begin
                if (row[2*j] && !lits[j]) begin
                    hit = 1'b0;
                end
                if (row[2*j+1] && lits[j]) begin
                    hit = 1'b0;
                end
            end
        end

        assign terms[t] = hit;
    end

endmodule

// File: rtl/pal_macrocell.sv
`timescale 1ns/1ps
// Module: one output cell with sum gate, register, polarity, output enable and feedback select.
// Assumes the clear term is glitch-free relative to clk; clear beats reset, preload and set.
module pal_macrocell #(
    parameter int N_PT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_en,
    input  logic [N_PT-1:0] pts,
    input  logic            oe_pt,
    input  logic            reg_mode,
    input  logic            invert,
    input  logic            ar_hit,
    input  logic            ss_hit,
    input  logic            pre_en,
    input  logic            pre_bit,
    input  logic            pin_i,
    output logic            q,
    output logic            pin_o,
    output logic            pin_oe,
    output logic            fb
);
    logic sum;
    logic level;

    // OR of the product terms owned by this cell.
    assign sum = |pts;

    // Register: asynchronous clear by term, then reset/configure, preload, set, logic.
    always_ff @(posedge clk or posedge ar_hit) begin
        if (ar_hit) begin
            q <= 1'b0;
        end else if (!rst_n || cfg_en) begin
            q <= 1'b0;
        end else if (pre_en) begin
            q <= pre_bit;
        end else if (ss_hit) begin
            q <= 1'b1;
        end else begin
            q <= sum;
        end
    end

    // Output path: pick register or sum, then apply polarity.
    assign level  = reg_mode ? q : sum;
    assign pin_o  = level ^ invert;
    assign pin_oe = oe_pt & ~cfg_en;

    // Feedback into the array: register when registered, pad level otherwise.
    assign fb = reg_mode ? q : pin_i;

endmodule

// File: rtl/pal_array_top.sv
`timescale 1ns/1ps
// Module: configurable sum-of-products logic array with ten output cells.
// Assumes row map: sum terms first (per cell, in cell order), then one enable row per cell,
// then the clear row, the set row, and finally the control row.
module pal_array_top #(
    parameter int N_DIN   = 11,
    parameter int N_MC    = 10,
    parameter int PT_MIN  = 8,
    parameter int PT_STEP = 2,
    localparam int N_AIN   = N_DIN + N_MC,
    localparam int ROW_W   = 2 * N_AIN,
    localparam int N_SUM   = pal_cfg_pkg::pt_offset(N_MC, N_MC, PT_MIN, PT_STEP),
    localparam int N_TERMS = N_SUM + N_MC + 2,
    localparam int AW      = $clog2(N_TERMS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [ROW_W-1:0] cfg_data,
    input  logic [N_DIN-1:0] din,
    input  logic [N_MC-1:0]  pin_i,
    input  logic             pre_en,
    input  logic [N_MC-1:0]  pre_data,
    output logic [N_MC-1:0]  pin_o,
    output logic [N_MC-1:0]  pin_oe
);
    localparam int OE_BASE = N_SUM;
    localparam int AR_ROW  = N_SUM + N_MC;
    localparam int SS_ROW  = N_SUM + N_MC + 1;

    logic [N_TERMS*ROW_W-1:0] plane;
    logic [N_MC-1:0]          reg_mode;
    logic [N_MC-1:0]          invert;
    logic [N_MC-1:0]          fb;
    logic [N_MC-1:0]          q_state;
    logic [N_AIN-1:0]         lits;
    logic [N_TERMS-1:0]       terms;
    logic                     ar_hit;
    logic                     ss_hit;

    pal_fuse_store #(
        .N_TERMS (N_TERMS),
        .ROW_W   (ROW_W),
        .N_MC    (N_MC),
        .AW      (AW)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .plane    (plane),
        .reg_mode (reg_mode),
        .invert   (invert)
    );

    // Array inputs: dedicated pins low, cell feedback above them.
    assign lits = {fb, din};

    pal_and_plane #(
        .N_TERMS (N_TERMS),
        .N_AIN   (N_AIN)
    ) u_plane (
        .fuses (plane),
        .lits  (lits),
        .terms (terms)
    );

    // Shared control terms for all registers.
    assign ar_hit = terms[AR_ROW];
    assign ss_hit = terms[SS_ROW];

    for (genvar i = 0; i < N_MC; i++) begin : g_cell
        localparam int CNT = pal_cfg_pkg::pt_count(i, N_MC, PT_MIN, PT_STEP);
        localparam int OFF = pal_cfg_pkg::pt_offset(i, N_MC, PT_MIN, PT_STEP);

        pal_macrocell #(
            .N_PT (CNT)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_en   (cfg_en),
            .pts      (terms[OFF +: CNT]),
            .oe_pt    (terms[OE_BASE + i]),
            .reg_mode (reg_mode[i]),
            .invert   (invert[i]),
            .ar_hit   (ar_hit),
            .ss_hit   (ss_hit),
            .pre_en   (pre_en),
            .pre_bit  (pre_data[i]),
            .pin_i    (pin_i[i]),
            .q        (q_state[i]),
            .pin_o    (pin_o[i]),
            .pin_oe   (pin_oe[i]),
            .fb       (fb[i])
        );
    end

endmodule

// File: rtl/pal_array_chk.sv
`timescale 1ns/1ps
// Module: property checker for the logic array, attached to the top through bind.
// Assumes the clear term is driven only by dedicated inputs that change away from the clock edge.
module pal_array_chk #(
    parameter int N_MC = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            pre_en,
    input logic [N_MC-1:0] pre_data,
    input logic            ar_hit,
    input logic            ss_hit,
    input logic [N_MC-1:0] q_state,
    input logic [N_MC-1:0] pin_oe
);
    AST_CFG_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> pin_oe == '0); // R5

    AST_CLEAR_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        ar_hit |-> q_state == '0); // R8

    AST_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !pre_en && ss_hit && !ar_hit) |=> (ar_hit || q_state == '1)); // R7

    AST_PRELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && pre_en && !ar_hit) |=> (ar_hit || q_state == $past(pre_data))); // R9

    AST_CFG_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> q_state == '0); // R10

endmodule

bind pal_array_top pal_array_chk #(.N_MC(N_MC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .pre_en   (pre_en),
    .pre_data (pre_data),
    .ar_hit   (ar_hit),
    .ss_hit   (ss_hit),
    .q_state  (q_state),
    .pin_oe   (pin_oe)
);

// File: tb/test_pal_array_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random configurations, checked against a bench model.
module test_pal_array_top;
    localparam int N_DIN   = 11;
    localparam int N_MC    = 10;
    localparam int N_AIN   = N_DIN + N_MC;
    localparam int ROW_W   = 2 * N_AIN;
    localparam int N_SUM   = 120;
    localparam int N_TERMS = N_SUM + N_MC + 2;
    localparam int ROW_AR  = N_SUM + N_MC;
    localparam int ROW_SS  = N_SUM + N_MC + 1;
    localparam int ROW_CTL = N_TERMS;
    localparam int AW      = 8;

    logic             clk;
    logic             rst_n;
    logic             cfg_en;
    logic             cfg_we;
    logic [AW-1:0]    cfg_addr;
    logic [ROW_W-1:0] cfg_data;
    logic [N_DIN-1:0] din;
    logic [N_MC-1:0]  pin_i;
    logic             pre_en;
    logic [N_MC-1:0]  pre_data;
    logic [N_MC-1:0]  pin_o;
    logic [N_MC-1:0]  pin_oe;

    pal_array_top i_pal_array_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .din      (din),
        .pin_i    (pin_i),
        .pre_en   (pre_en),
        .pre_data (pre_data),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_chk;
    int n_err;
    bit done;

    logic [ROW_W-1:0] m_rows [N_TERMS];
    logic [N_MC-1:0]  m_reg, m_inv, m_q;
    logic [ROW_W-1:0] c_rows [N_TERMS];
    logic [N_MC-1:0]  c_reg, c_inv;

    function automatic int cnt_of(int i);
        return (i < 5) ? 8 + 2 * i : 8 + 2 * (9 - i);
    endfunction

    function automatic int off_of(int i);
        int s;
        s = 0;
        for (int k = 0; k < i; k++) s += cnt_of(k);
        return s;
    endfunction

    // Term value: every connected fuse must meet a true literal.
    function automatic logic term_of(logic [ROW_W-1:0] row, logic [N_AIN-1:0] l);
        logic [ROW_W-1:0] pv;
        for (int j = 0; j < N_AIN; j++) begin
            pv[2*j]   = l[j];
            pv[2*j+1] = ~l[j];
        end
        return &(pv | ~row);
    endfunction

    function automatic logic [ROW_W-1:0] lit(int j, int comp);
        return ROW_W'(1) << (2 * j + comp);
    endfunction

    function automatic logic [ROW_W-1:0] rnd_row(int n, int span);
        logic [ROW_W-1:0] r;
        r = '0;
        for (int k = 0; k < n; k++) begin
            r = r | lit(int'($urandom % span), int'($urandom % 2));
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [N_MC-1:0] act, logic [N_MC-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Expected outputs now and register value after the coming edge.
    task automatic predict(output logic [N_MC-1:0] e_o, output logic [N_MC-1:0] e_oe,
                           output logic [N_MC-1:0] e_nx);
        logic [N_AIN-1:0] l;
        logic [N_MC-1:0]  fbv, qe, sm, lvl;
        logic             ar, ss;
        fbv = (m_reg & m_q) | (~m_reg & pin_i);
        l   = {fbv, din};
        ar  = term_of(m_rows[ROW_AR], l);
        qe  = ar ? '0 : m_q;
        fbv = (m_reg & qe) | (~m_reg & pin_i);
        l   = {fbv, din};
        ss  = term_of(m_rows[ROW_SS], l);
        for (int i = 0; i < N_MC; i++) begin
            sm[i] = 1'b0;
            for (int k = 0; k < cnt_of(i); k++) sm[i] = sm[i] | term_of(m_rows[off_of(i) + k], l);
            e_oe[i] = term_of(m_rows[N_SUM + i], l) & ~cfg_en;
        end
        lvl = (m_reg & qe) | (~m_reg & sm);
        e_o = lvl ^ m_inv;
        if (ar || !rst_n || cfg_en) e_nx = '0;
        else if (pre_en)            e_nx = pre_data;
        else if (ss)                e_nx = '1;
        else                        e_nx = sm;
    endtask

    // One clock: compare before the edge, update the model after it, return at falling edge + 1.
    task automatic run_cycle(string tag);
        logic [N_MC-1:0] e_o, e_oe, e_nx;
        #6;
        predict(e_o, e_oe, e_nx);
        chk({tag, " pin_o"}, pin_o, e_o);
        chk({tag, " pin_oe"}, pin_oe, e_oe);
        @(posedge clk);
        m_q = e_nx;
        if (!rst_n) begin
            for (int r = 0; r < N_TERMS; r++) m_rows[r] = '1;
            m_reg = '0;
            m_inv = '0;
        end else if (cfg_en && cfg_we) begin
            if (int'(cfg_addr) < N_TERMS) m_rows[cfg_addr] = cfg_data;
            else if (int'(cfg_addr) == ROW_CTL) begin
                m_reg = cfg_data[N_MC-1:0];
                m_inv = cfg_data[2*N_MC-1:N_MC];
            end
        end
        @(negedge clk);
        #1;
    endtask

    task automatic blank_cfg();
        for (int r = 0; r < N_TERMS; r++) c_rows[r] = '1;
        for (int i = 0; i < N_MC; i++) c_rows[N_SUM + i] = '0;
        c_reg = '0;
        c_inv = '0;
    endtask

    task automatic load_cfg();
        din      = '0;
        pre_en   = 1'b0;
        cfg_en   = 1'b1;
        cfg_we   = 1'b1;
        for (int r = 0; r <= N_TERMS; r++) begin
            cfg_addr = AW'(r);
            cfg_data = (r < N_TERMS) ? c_rows[r] : ROW_W'({c_inv, c_reg});
            run_cycle("R10 cfg write");
        end
        cfg_we = 1'b0;
        run_cycle("R5 R10 cfg hold");
        cfg_en = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N_MC-1:0] ex, eoe;
        void'($urandom(32'h5A17));
        n_chk = 0; n_err = 0; done = 1'b0;
        for (int r = 0; r < N_TERMS; r++) m_rows[r] = '1;
        m_reg = '0; m_inv = '0; m_q = '0;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
        din = '0; pin_i = '0; pre_en = 1'b0; pre_data = '0;
        @(negedge clk);
        #1;
        run_cycle("R11 reset");
        rst_n = 1'b1;
        run_cycle("R11 after reset");
        chk("R11 reset oe", pin_oe, '0);
        chk("R11 reset out", pin_o, '0);

        // R10: strobe without configure mode is ignored.
        cfg_we = 1'b1; cfg_addr = AW'(N_SUM); cfg_data = '0;
        run_cycle("R10 stray write");
        cfg_we = 1'b0;
        run_cycle("R10 stray write");
        chk("R10 write ignored oe", pin_oe, '0);

        // Directed A: combinational literals, map boundaries, polarity, pad feedback.
        blank_cfg();
        c_rows[off_of(0)]                 = lit(0, 0);
        c_rows[off_of(1)]                 = lit(1, 1);
        c_rows[off_of(4) + cnt_of(4) - 1] = lit(2, 0);
        c_rows[off_of(5)]                 = lit(3, 0);
        c_rows[off_of(3)]                 = lit(N_DIN + 3, 0);
        c_rows[N_SUM]                     = lit(4, 0);
        c_inv[2] = 1'b1;
        load_cfg();
        for (int n = 0; n < 8; n++) begin
            din = N_DIN'($urandom); pin_i = N_MC'($urandom);
            run_cycle("R1 R2 R3 R6 comb");
            ex = '0;
            ex[0] = din[0]; ex[1] = ~din[1]; ex[2] = 1'b1;
            ex[3] = pin_i[3]; ex[4] = din[2]; ex[5] = din[3];
            chk("R1 R2 R3 R6 literal map", pin_o, ex);
            eoe = '1; eoe[0] = din[4];
            chk("R5 enable term", pin_oe, eoe);
        end

        // Directed B: registered cells, set, preload, clear and their priority.
        blank_cfg();
        c_reg = '1; c_inv[9] = 1'b1;
        c_rows[off_of(0)] = lit(N_DIN + 0, 1);
        for (int i = 1; i < N_MC; i++) c_rows[off_of(i)] = lit(5, 0);
        c_rows[ROW_SS] = lit(6, 0);
        c_rows[ROW_AR] = lit(7, 0);
        load_cfg();
        din = '0; pin_i = '0;
        run_cycle("R4 R6 toggle");
        chk("R4 R6 register feedback", pin_o, 10'h201);
        run_cycle("R4 R6 toggle");
        chk("R4 R6 register feedback", pin_o, 10'h200);
        din[5] = 1'b1;
        run_cycle("R4 capture");
        chk("R4 capture ones", pin_o, 10'h1FF);
        din[6] = 1'b1; pre_en = 1'b1; pre_data = 10'h2A5;
        run_cycle("R9 preload");
        chk("R9 preload beats set", pin_o, 10'h0A5);
        pre_en = 1'b0; din[5] = 1'b0;
        run_cycle("R7 set");
        chk("R7 set all", pin_o, 10'h1FF);
        din[7] = 1'b1;
        #1;
        chk("R8 clear without edge", pin_o, 10'h200);
        run_cycle("R8 clear");
        chk("R8 clear beats set", pin_o, 10'h200);
        pre_en = 1'b1; pre_data = '1;
        run_cycle("R8 clear");
        chk("R8 clear beats preload", pin_o, 10'h200);
        pre_en = 1'b0; din = '0;
        run_cycle("R4 resume");

        // R11: reset mid-run returns fuses and registers to their initial state.
        rst_n = 1'b0;
        run_cycle("R11 midrun");
        rst_n = 1'b1;
        run_cycle("R11 midrun");
        chk("R11 midrun oe", pin_oe, '0);
        chk("R11 midrun out", pin_o, '0);

        // Random configurations; clear rows use dedicated inputs only.
        for (int c = 0; c < 6; c++) begin
            for (int r = 0; r < N_SUM; r++) begin
                case ($urandom % 8)
                    0:       c_rows[r] = '1;
                    1:       c_rows[r] = '0;
                    default: c_rows[r] = rnd_row(1 + int'($urandom % 3), N_AIN);
                endcase
            end
            for (int i = 0; i < N_MC; i++)
                c_rows[N_SUM + i] = ($urandom % 4 == 0) ? rnd_row(1, N_AIN) : '0;
            c_rows[ROW_AR] = ($urandom % 3 == 0) ? rnd_row(3, N_DIN) : '1;
            c_rows[ROW_SS] = ($urandom % 2 == 0) ? rnd_row(2, N_AIN) : '1;
            c_reg = N_MC'($urandom);
            c_inv = N_MC'($urandom);
            load_cfg();
            for (int n = 0; n < 250; n++) begin
                din      = N_DIN'($urandom);
                pin_i    = N_MC'($urandom);
                pre_en   = ($urandom % 10 == 0);
                pre_data = N_MC'($urandom);
                run_cycle("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule